// File: doc/BRIEF.md
# Handshaked Device Port Controller

This block sits between a host register bus and a simple byte-wide device. The host sees four 8-bit registers: a status register, a command register, a receive holding register that the device fills, and a transmit holding register that the host fills. Commands run under a two-bit handshake. The host polls the busy flag until it reads clear, loads the transmit byte, then writes the command register with the write and go bits set. The controller raises busy, offers the byte to the device on a valid/ready pair, and in a single completion step drops go, busy and the error flag.

The device pushes bytes into the receive register. A flag marks each byte as available until the host reads it. An error flag records a transfer that timed out, a register write refused because the controller was busy, and a received byte that overwrote an unread one. An optional one-cycle interrupt marks each completion. The transfer time limit in cycles is a static configuration input.

Top module: `hsport_ctrl`

## Requirements
- R1: After reset, the status, command, receive and transmit registers read 0, and `irq` and `dev_tx_valid` are low.
- R2: Register map by `host_addr`: 0 = status (bit0 busy, bit1 error, bit2 rx-available), 1 = command (bit0 go, bit1 write, bit2 interrupt enable), 2 = receive byte, 3 = transmit byte. A read strobe returns the addressed value on `host_rdata` one cycle later. The transmit and command registers read back what was written.
- R3: Busy becomes visible one clock after the edge that stores go = 1. A status read launched in the cycle right after the command write returns busy = 0, and the following read returns busy = 1.
- R4: With write = 1, `dev_tx_valid` rises together with busy and presents the transmit byte captured at start. That byte stays stable until `dev_tx_ready`. The handshake edge clears go, busy and error together.
- R5: A command with go = 1 and write = 0 keeps busy high for exactly one cycle. It never raises `dev_tx_valid`, then completes like a transfer.
- R6: While busy is 1, a host write to the transmit or command register leaves that register unchanged and sets error.
- R7: A `dev_rx_valid` pulse loads `dev_rx_data` into the receive register and sets rx-available. A host read of the receive register clears rx-available.
- R8: A byte that arrives while rx-available is set replaces the old byte and sets error. If it arrives in the same cycle as a host read of the receive register, the read returns the old byte, rx-available stays set, and error is not set.
- R9: When interrupt enable is 1, `irq` is high for exactly one cycle, the cycle in which busy has just fallen. When it is 0, `irq` stays low.
- R10: If `dev_tx_ready` stays low for `tmo_cycles` consecutive valid cycles, the controller drops `dev_tx_valid`, sets error, and clears go and busy.
- R11: When the completion step and any error-setting event fall on the same edge, error ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data |
| tmo_cycles | input | TMO_W | Transfer time limit in cycles |
| dev_tx_data | output | DATA_W | Byte offered to the device |
| dev_tx_valid | output | 1 | Byte offered |
| dev_tx_ready | input | 1 | Device accepts the byte |
| dev_rx_data | input | DATA_W | Byte from the device |
| dev_rx_valid | input | 1 | Device byte strobe |
| irq | output | 1 | Completion pulse |

## Verification
Two functions can share one clock edge. The completion step wants to clear the error flag, while a receive overrun wants to set it. The bench provokes this by pulsing `dev_rx_valid` with a second unread byte in the same cycle that it raises `dev_tx_ready`. A status read must then show error set with busy clear, and the command read must show go cleared. A second coincidence, a host read of the receive register in the cycle a new byte lands, is judged by the value returned, by rx-available staying set, and by error staying clear.

// File: rtl/hsport_pkg.sv
package hsport_pkg;
  localparam logic [1:0] ADR_STAT = 2'd0;
  localparam logic [1:0] ADR_CMD  = 2'd1;
  localparam logic [1:0] ADR_RXB  = 2'd2;
  localparam logic [1:0] ADR_TXB  = 2'd3;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SEND, ENG_FIN} eng_state_t;
endpackage

// File: rtl/hsport_engine.sv
module hsport_engine
  import hsport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              wr_cmd,
  input  logic [DATA_W-1:0] txb,
  input  logic [TMO_W-1:0]  tmo_cycles,
  input  logic              dev_tx_ready,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              dev_tx_valid,
  output logic [DATA_W-1:0] dev_tx_data
);
  eng_state_t       state;
  logic [TMO_W-1:0] wait_cnt;

  assign dev_tx_valid = (state == ENG_SEND);

  always_comb begin
    done = 1'b0;
    fail = 1'b0;
    case (state)
      ENG_SEND: begin
        if (dev_tx_ready) begin
          done = 1'b1;
        end else if (({1'b0, wait_cnt} + 1'b1) >= {1'b0, tmo_cycles}) begin
          done = 1'b1;
          fail = 1'b1;
        end
      end
      ENG_FIN: done = 1'b1;
      default: done = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ENG_IDLE;
      busy        <= 1'b0;
      wait_cnt    <= '0;
      dev_tx_data <= '0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (go) begin
            busy        <= 1'b1;
            wait_cnt    <= '0;
            dev_tx_data <= txb;
            state       <= wr_cmd ? ENG_SEND : ENG_FIN;
          end
        end
        ENG_SEND: begin
          if (done) begin
            busy  <= 1'b0;
            state <= ENG_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: begin
          busy  <= 1'b0;
          state <= ENG_IDLE;
        end
      endcase
    end
  end

  // R3: busy only rises after go was seen
  assert_busy_after_go_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go));

  // R4: offered byte held while the device stalls
  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (dev_tx_valid && !dev_tx_ready && !fail) |=> (dev_tx_valid && $stable(dev_tx_data)));

  // R10: an expired wait ends the command
  assert_timeout_ends_R10: assert property (@(posedge clk) disable iff (rst)
    (dev_tx_valid && fail) |=> (!busy && !dev_tx_valid));
endmodule

// File: rtl/hsport_rx.sv
module hsport_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_rx_valid,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              rd_take,
  output logic [DATA_W-1:0] rxb,
  output logic              rx_avail,
  output logic              overrun
);
  assign overrun = dev_rx_valid && rx_avail && !rd_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxb      <= '0;
      rx_avail <= 1'b0;
    end else if (dev_rx_valid) begin
      rxb      <= dev_rx_data;
      rx_avail <= 1'b1;
    end else if (rd_take) begin
      rx_avail <= 1'b0;
    end
  end

  // R7: an arriving byte is always flagged
  assert_rx_flag_R7: assert property (@(posedge clk) disable iff (rst)
    dev_rx_valid |=> rx_avail);

  // R7: a lone read drains the flag
  assert_rx_drain_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_take && !dev_rx_valid) |=> !rx_avail);
endmodule

// File: rtl/hsport_regs.sv
module hsport_regs
  import hsport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              fail,
  input  logic              overrun,
  input  logic [DATA_W-1:0] rxb,
  input  logic              rx_avail,
  output logic              go,
  output logic              wr_cmd,
  output logic              irq_en,
  output logic [DATA_W-1:0] txb,
  output logic              rd_take,
  output logic              irq
);
  localparam int PAD = DATA_W - 3;

  logic err;
  logic hit_cmd, hit_txb, refused, err_set;

  assign hit_cmd = host_wr && (host_addr == ADR_CMD);
  assign hit_txb = host_wr && (host_addr == ADR_TXB);
  assign refused = busy && (hit_cmd || hit_txb);
  assign rd_take = host_rd && (host_addr == ADR_RXB);
  assign err_set = refused || overrun || (done && fail);

  always_ff @(posedge clk) begin
    if (rst) begin
      go     <= 1'b0;
      wr_cmd <= 1'b0;
      irq_en <= 1'b0;
      txb    <= '0;
      err    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= done && irq_en;
      if (err_set) err <= 1'b1;
      else if (done) err <= 1'b0;
      if (done) begin
        go <= 1'b0;
      end else if (hit_cmd && !busy) begin
        go     <= host_wdata[0];
        wr_cmd <= host_wdata[1];
        irq_en <= host_wdata[2];
      end
      if (hit_txb && !busy) txb <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (host_addr)
        ADR_STAT: host_rdata <= {{PAD{1'b0}}, rx_avail, err, busy};
        ADR_CMD:  host_rdata <= {{PAD{1'b0}}, irq_en, wr_cmd, go};
        ADR_RXB:  host_rdata <= rxb;
        default:  host_rdata <= txb;
      endcase
    end
  end

  // R4: busy never falls while go remains
  assert_fall_clears_go_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !go);

  // R6: refused transmit write keeps the byte and flags error
  assert_refused_write_R6: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == ADR_TXB && busy) |=> ($stable(txb) && err));

  // R9: interrupt pulse only as busy has just fallen
  assert_irq_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && $past(busy)));

  // R11: a set on the completion edge wins
  assert_err_priority_R11: assert property (@(posedge clk) disable iff (rst)
    (done && overrun) |=> err);
endmodule

// File: rtl/hsport_ctrl.sv
module hsport_ctrl #(
  parameter int DATA_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [TMO_W-1:0]  tmo_cycles,
  output logic [DATA_W-1:0] dev_tx_data,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              dev_rx_valid,
  output logic              irq
);
  logic              busy, done, fail, go, wr_cmd, irq_en, rd_take;
  logic              rx_avail, overrun;
  logic [DATA_W-1:0] txb, rxb;

  hsport_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .done(done), .fail(fail), .overrun(overrun),
    .rxb(rxb), .rx_avail(rx_avail), .go(go), .wr_cmd(wr_cmd),
    .irq_en(irq_en), .txb(txb), .rd_take(rd_take), .irq(irq)
  );

  hsport_engine #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_engine (
    .clk(clk), .rst(rst), .go(go), .wr_cmd(wr_cmd), .txb(txb),
    .tmo_cycles(tmo_cycles), .dev_tx_ready(dev_tx_ready), .busy(busy),
    .done(done), .fail(fail), .dev_tx_valid(dev_tx_valid),
    .dev_tx_data(dev_tx_data)
  );

  hsport_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .dev_rx_valid(dev_rx_valid),
    .dev_rx_data(dev_rx_data), .rd_take(rd_take), .rxb(rxb),
    .rx_avail(rx_avail), .overrun(overrun)
  );
endmodule

// File: tb/tb_hsport_ctrl.sv
module tb_hsport_ctrl;
  localparam int DW = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_rd = 0, host_wr = 0;
  logic [1:0]    host_addr = 0;
  logic [DW-1:0] host_wdata = 0;
  logic [DW-1:0] host_rdata;
  logic [TW-1:0] tmo_cycles = 16'd1000;
  logic [DW-1:0] dev_tx_data;
  logic          dev_tx_valid;
  logic          dev_tx_ready = 0;
  logic [DW-1:0] dev_rx_data = 0;
  logic          dev_rx_valid = 0;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  hsport_ctrl #(.DATA_W(DW), .TMO_W(TW)) dut (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tmo_cycles(tmo_cycles), .dev_tx_data(dev_tx_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
    .dev_rx_data(dev_rx_data), .dev_rx_valid(dev_rx_valid), .irq(irq)
  );

  function automatic logic [7:0] stat_val(logic avail, logic err, logic bsy);
    return {5'b0, avail, err, bsy};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(logic [1:0] a, logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    host_rd = 1; host_addr = a;
    @(negedge clk);
    host_rd = 0;
    d = host_rdata;
  endtask

  task automatic rx_push(logic [7:0] d);
    dev_rx_valid = 1; dev_rx_data = d;
    @(negedge clk);
    dev_rx_valid = 0;
  endtask

  task automatic do_tx(logic [7:0] d, logic ien, int delay, int tmo, logic rx_hit, string req);
    int k = 0, irqs = 0;
    logic hs = 0;
    logic [7:0] got = 0, v;
    logic exp_fail, exp_err;
    exp_fail = (delay >= tmo);
    exp_err  = exp_fail || rx_hit;
    tmo_cycles = TW'(tmo);
    wr(2'd3, d);
    wr(2'd1, {5'b0, ien, 2'b11});
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      dev_rx_valid = 0;
      if (irq) irqs++;
      if (dev_tx_valid) begin
        k++;
        dev_tx_ready = (k > delay);
        if (dev_tx_ready && !hs) begin
          got = dev_tx_data; hs = 1;
          if (rx_hit) begin dev_rx_valid = 1; dev_rx_data = 8'h77; end
        end
      end else if (k > 0) begin
        break;
      end
    end
    dev_tx_ready = 0;
    chk(req, k, exp_fail ? tmo : delay + 1, "valid cycles");
    chk(req, hs, !exp_fail, "handshake seen");
    if (!exp_fail) chk(req, got, d, "byte to device");
    chk("R9", irqs, ien ? 1 : 0, "irq pulses");
    rd(2'd0, v);
    chk(req, v[1:0], {exp_err, 1'b0}, "status error/busy");
    rd(2'd1, v);
    chk(req, v, {5'b0, ien, 2'b10}, "command after completion");
    if (rx_hit) begin
      rd(2'd2, v);
      chk("R11", v, 8'h77, "rx byte on completion edge");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1", irq, 0, "irq");
    chk("R1", dev_tx_valid, 0, "tx valid");
    rd(2'd0, v); chk("R1", v, 0, "status");
    rd(2'd1, v); chk("R1", v, 0, "command");
    rd(2'd2, v); chk("R1", v, 0, "rx byte");
    rd(2'd3, v); chk("R1", v, 0, "tx byte");

    // R2 readback
    wr(2'd3, 8'hA5); rd(2'd3, v); chk("R2", v, 8'hA5, "tx byte readback");
    wr(2'd1, 8'h04); rd(2'd1, v); chk("R2", v, 8'h04, "command readback");
    wr(2'd1, 8'h00);

    // R3 busy timing, R6 refused writes, R4 completion
    tmo_cycles = 16'd1000;
    wr(2'd3, 8'hC3);
    wr(2'd1, 8'h03);
    chk("R3", dev_tx_valid, 0, "valid right after go write");
    rd(2'd0, v); chk("R3", v, stat_val(0, 0, 0), "first status read");
    chk("R4", dev_tx_valid, 1, "valid raised");
    chk("R4", dev_tx_data, 8'hC3, "offered byte");
    rd(2'd0, v); chk("R3", v, stat_val(0, 0, 1), "second status read");
    wr(2'd3, 8'h33);
    rd(2'd3, v); chk("R6", v, 8'hC3, "tx byte kept while busy");
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R6", v, 8'h03, "command kept while busy");
    rd(2'd0, v); chk("R6", v, stat_val(0, 1, 1), "error after refused writes");
    chk("R4", dev_tx_data, 8'hC3, "byte stable while stalled");
    dev_tx_ready = 1;
    @(negedge clk);
    dev_tx_ready = 0;
    chk("R4", dev_tx_valid, 0, "valid dropped");
    rd(2'd0, v); chk("R4", v, stat_val(0, 0, 0), "busy and error cleared");
    rd(2'd1, v); chk("R4", v, 8'h02, "go cleared");

    // R5 command without write
    wr(2'd1, 8'h01);
    chk("R5", dev_tx_valid, 0, "no valid");
    rd(2'd0, v); chk("R5", v, stat_val(0, 0, 0), "pre-busy read");
    chk("R5", dev_tx_valid, 0, "no valid while busy");
    rd(2'd0, v); chk("R5", v, stat_val(0, 0, 1), "busy one cycle");
    rd(2'd0, v); chk("R5", v, stat_val(0, 0, 0), "busy gone");
    rd(2'd1, v); chk("R5", v, 8'h00, "command after");

    // R9 interrupt on and off
    do_tx(8'h5C, 1'b1, 2, 1000, 1'b0, "R9");
    do_tx(8'hE1, 1'b0, 0, 1000, 1'b0, "R9");

    // R7 receive path
    rx_push(8'h5A);
    rd(2'd0, v); chk("R7", v, stat_val(1, 0, 0), "rx available");
    rd(2'd2, v); chk("R7", v, 8'h5A, "rx byte");
    rd(2'd0, v); chk("R7", v, stat_val(0, 0, 0), "rx drained");

    // R8 overrun
    rx_push(8'h11);
    rx_push(8'h22);
    rd(2'd0, v); chk("R8", v, stat_val(1, 1, 0), "overrun status");
    rd(2'd2, v); chk("R8", v, 8'h22, "newest byte kept");
    do_tx(8'h01, 1'b0, 0, 1000, 1'b0, "R4");

    // R8 read and arrival together
    rx_push(8'h44);
    host_rd = 1; host_addr = 2'd2; dev_rx_valid = 1; dev_rx_data = 8'h55;
    @(negedge clk);
    host_rd = 0; dev_rx_valid = 0;
    chk("R8", host_rdata, 8'h44, "old byte returned");
    rd(2'd0, v); chk("R8", v, stat_val(1, 0, 0), "still available no error");
    rd(2'd2, v); chk("R8", v, 8'h55, "new byte");

    // R10 timeout
    do_tx(8'h9D, 1'b1, 10, 3, 1'b0, "R10");
    do_tx(8'h9E, 1'b0, 4, 4, 1'b0, "R10");
    do_tx(8'h9F, 1'b0, 0, 1, 1'b0, "R10");

    // R11 overrun on the completion edge
    rx_push(8'h66);
    do_tx(8'hB4, 1'b0, 1, 1000, 1'b1, "R11");
    do_tx(8'h02, 1'b0, 0, 1000, 1'b0, "R4");

    // random transfers
    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      int dl, tm;
      logic ie;
      d  = 8'($urandom);
      dl = int'($urandom % 6);
      tm = 1 + int'($urandom % 6);
      ie = 1'($urandom);
      do_tx(d, ie, dl, tm, 1'b0, (dl >= tm) ? "R10" : "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule